// File: doc/BRIEF.md
# Vertical-Sync-Clocked Display Identification Transmitter

This block sends display identification bytes out one way on a single serial data line. It has no bus clock of its own. Each bit period begins on a rising edge of the monitor's vertical-sync signal, after that signal has been brought into the system clock domain. The host writes bytes into a holding register. On the first strobe of a new byte, the block copies the holding register into its shift register. It then sends the eight data bits starting with the most significant. A ninth period follows in which the line is released high, and after that the next byte starts.

Three sticky interrupt flags keep the host informed. One is set each time a byte is loaded, which tells the host it may queue the next byte. One is set on every vertical-sync strobe. One is set when a load finds that no new byte was written since the previous load; in that case the old byte is sent again. The host clears a flag by writing a one to its clear bit. Transmission runs only while the enable input is high. While it is low, the line idles high and the byte sequence starts over from the beginning.

Top module: `ddc1_vsync_tx`

## Requirements
- R1: After reset, `sda_out` is 1, all bits of `irq_flags` are 0, and the holding register holds 0.
- R2: While `enable` is 0, `sda_out` is driven to 1 on the next clock, no byte is loaded, and the transmit flag (bit 0) is not set. Vsync strobes still set the vsync flag.
- R3: After `enable` rises, `sda_out` stays 1 until the first vsync strobe loads a byte.
- R4: A vsync strobe takes effect on the third rising clock edge after the first edge that samples `vsync_in` high (with the default of two synchronizer stages). `vsync_in` held high for any length of time gives exactly one strobe.
- R5: The loading strobe drives bit 7 of the byte onto `sda_out`. The next seven strobes drive bits 6 down to 0 in that order.
- R6: The ninth strobe of a byte drives `sda_out` to 1 (null bit). The tenth strobe loads the next byte.
- R7: Each load sets `irq_flags[0]` (transmit ready). A host write in the same clock as a load queues the written byte for the following load.
- R8: Each vsync strobe sets `irq_flags[1]`, whether or not the block is enabled.
- R9: A load with no host write since the previous load (or since reset) sends the holding register again unchanged and sets `irq_flags[2]` (underrun).
- R10: A set flag stays set until its bit in `irq_clr` is 1 for a clock. If a set and a clear for the same flag come in the same clock, the set wins.
- R11: Taking `enable` low in the middle of a byte abandons that byte. The first strobe after re-enabling loads the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Transmission enable |
| host_wr | input | 1 | Write strobe for the holding register |
| host_data | input | 8 | Byte written by the host |
| irq_clr | input | 3 | Write-one-to-clear for the flags (bit 0 transmit, bit 1 vsync, bit 2 underrun) |
| vsync_in | input | 1 | Asynchronous vertical-sync input |
| sda_out | output | 1 | Serial data line |
| irq_flags | output | 3 | Sticky flags: bit 0 transmit ready, bit 1 vsync, bit 2 underrun |

## Verification
A bit counter that is off by one shows up at the port within a byte. Either the null bit lands where a data bit should be, or a load comes a strobe early or late. Both show on `sda_out` and `irq_flags[0]` by the tenth strobe. An edge detector that fires again while vsync is held high advances `sda_out` or sets the vsync flag after a clear within that same high pulse. A wrong fresh-byte marker sets or misses the underrun flag in the clock of the load itself. The reference model is compared with both outputs on every clock, so each of these faults is reported in the cycle it first shows.

// File: rtl/ddc1_tx_pkg.sv
package ddc1_tx_pkg;
   localparam int FLAG_TX   = 0;
   localparam int FLAG_VS   = 1;
   localparam int FLAG_URUN = 2;
   localparam int FLAG_NUM  = 3;

   function automatic int cnt_bits(input int data_w);
      return $clog2(data_w + 1);
   endfunction
endpackage

// File: rtl/ddc1_vsync_edge.sv
module ddc1_vsync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ddc1_vsync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/ddc1_bit_shifter.sv
module ddc1_bit_shifter #(
   parameter int   DATA_W     = 8,
   parameter logic NULL_LEVEL = 1'b1,
   parameter logic IDLE_LEVEL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              step,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              sda_o,
   output logic              load_o,
   output logic              underrun_o
);
   localparam int CW = ddc1_tx_pkg::cnt_bits(DATA_W);
   localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("ddc1_bit_shifter: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] hold_q;
   logic [DATA_W-1:0] shift_q;
   logic [CW-1:0]     pos_q;
   logic              fresh_q;
   logic              sda_q;
   logic              at_start;

   assign at_start   = (pos_q == '0);
   assign load_o     = enable & step & at_start;
   assign underrun_o = load_o & ~fresh_q;
   assign sda_o      = sda_q;

   // holding register and its fresh marker
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         fresh_q <= 1'b0;
      end else begin
         if (wr_i) begin
            hold_q  <= wr_data_i;
            fresh_q <= 1'b1;
         end else if (load_o) begin
            fresh_q <= 1'b0;
         end
      end
   end

   // bit sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         pos_q   <= '0;
         sda_q   <= IDLE_LEVEL;
      end else if (!enable) begin
         pos_q <= '0;
         sda_q <= IDLE_LEVEL;
      end else if (step) begin
         if (at_start) begin
            sda_q   <= hold_q[DATA_W-1];
            shift_q <= {hold_q[DATA_W-2:0], 1'b0};
            pos_q   <= CW'(1);
         end else if (pos_q < LAST_BIT) begin
            sda_q   <= shift_q[DATA_W-1];
            shift_q <= {shift_q[DATA_W-2:0], 1'b0};
            pos_q   <= pos_q + CW'(1);
         end else begin
            sda_q <= NULL_LEVEL;
            pos_q <= '0;
         end
      end
   end
endmodule

// File: rtl/ddc1_irq_flags.sv
module ddc1_irq_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   generate
      for (genvar g = 0; g < N; g++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flag_o[g] <= 1'b0;
            else if (set_i[g])   flag_o[g] <= 1'b1;
            else if (clr_i[g])   flag_o[g] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/ddc1_vsync_tx.sv
module ddc1_vsync_tx #(
   parameter int   DATA_W      = 8,
   parameter int   SYNC_STAGES = 2,
   parameter logic NULL_LEVEL  = 1'b1,
   parameter logic IDLE_LEVEL  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_data,
   input  logic [2:0]        irq_clr,
   input  logic              vsync_in,
   output logic              sda_out,
   output logic [2:0]        irq_flags
);
   import ddc1_tx_pkg::*;

   logic                vs_step;
   logic                byte_load;
   logic                byte_urun;
   logic [FLAG_NUM-1:0] flag_set;

   ddc1_vsync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(vsync_in),
      .rise_o  (vs_step)
   );

   ddc1_bit_shifter #(
      .DATA_W    (DATA_W),
      .NULL_LEVEL(NULL_LEVEL),
      .IDLE_LEVEL(IDLE_LEVEL)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .step      (vs_step),
      .wr_i      (host_wr),
      .wr_data_i (host_data),
      .sda_o     (sda_out),
      .load_o    (byte_load),
      .underrun_o(byte_urun)
   );

   always_comb begin
      flag_set            = '0;
      flag_set[FLAG_TX]   = byte_load;
      flag_set[FLAG_VS]   = vs_step;
      flag_set[FLAG_URUN] = byte_urun;
   end

   ddc1_irq_flags #(.N(FLAG_NUM)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (flag_set),
      .clr_i (irq_clr),
      .flag_o(irq_flags)
   );
endmodule

// File: rtl/ddc1_vsync_tx_chk.sv
module ddc1_vsync_tx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       enable,
   input logic [2:0] irq_clr,
   input logic       sda_out,
   input logic [2:0] irq_flags,
   input logic       step
);
   // R2
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> sda_out);

   // R7
   tx_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flags[0]) |-> $past(enable));

   // R10
   vs_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flags[1] && !irq_clr[1]) |=> irq_flags[1]);

   // R4
   sda_moves_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_out) |-> $past(step || !enable));

   // R9
   urun_with_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flags[2]) |-> irq_flags[0]);

   // R8
   vs_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> irq_flags[1]);
endmodule

bind ddc1_vsync_tx ddc1_vsync_tx_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .irq_clr  (irq_clr),
   .sda_out  (sda_out),
   .irq_flags(irq_flags),
   .step     (vs_step)
);

// File: tb/tb_ddc1_vsync_tx.sv
module tb_ddc1_vsync_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       host_wr = 1'b0;
   logic [7:0] host_data = 8'h00;
   logic [2:0] irq_clr = 3'b000;
   logic       vsync_in = 1'b0;
   logic       sda_out;
   logic [2:0] irq_flags;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   ddc1_vsync_tx dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .host_wr(host_wr),
      .host_data(host_data), .irq_clr(irq_clr), .vsync_in(vsync_in),
      .sda_out(sda_out), .irq_flags(irq_flags)
   );

   // behavioural reference model
   bit       hv[3];
   int       m_pos;
   bit [7:0] m_hold, m_shift;
   bit       m_fresh, m_sda;
   bit [2:0] m_flags;

   always @(posedge clk) begin
      bit st, ld;
      bit [2:0] setv;
      if (!rst_n) begin
         hv = '{0, 0, 0};
         m_pos = 0; m_hold = 0; m_shift = 0; m_fresh = 0; m_sda = 1; m_flags = 0;
      end else begin
         st = hv[1] && !hv[2];
         hv[2] = hv[1]; hv[1] = hv[0]; hv[0] = vsync_in;
         ld = enable && st && (m_pos == 0);
         setv = {ld && !m_fresh, st, ld};
         if (!enable) begin
            m_pos = 0; m_sda = 1;
         end else if (st) begin
            if (m_pos == 0) begin
               m_shift = m_hold; m_sda = m_shift[7]; m_pos = 1;
            end else if (m_pos < 8) begin
               m_sda = m_shift[7 - m_pos]; m_pos++;
            end else begin
               m_sda = 1; m_pos = 0;
            end
         end
         if (host_wr) begin
            m_hold = host_data; m_fresh = 1;
         end else if (ld) m_fresh = 0;
         m_flags = setv | (m_flags & ~irq_clr);
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R5 sda_out vs model", sda_out, m_sda);
         chk("R10 irq_flags vs model", irq_flags, m_flags);
      end
   end

   task automatic vpulse();
      @(negedge clk) vsync_in = 1;
      repeat (4) @(negedge clk);
      vsync_in = 0;
      repeat (4) @(negedge clk);
   endtask

   task automatic hwrite(input bit [7:0] d);
      @(negedge clk) begin host_wr = 1; host_data = d; end
      @(negedge clk) host_wr = 0;
   endtask

   task automatic clr(input bit [2:0] m);
      @(negedge clk) irq_clr = m;
      @(negedge clk) irq_clr = 0;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 sda in reset", sda_out, 1);
      rst_n = 1;
      @(negedge clk);
      chk("R1 sda after reset", sda_out, 1);
      chk("R1 flags after reset", irq_flags, 0);

      // disabled: vsync flag only
      vpulse();
      chk("R2 sda disabled", sda_out, 1);
      chk("R2 no tx flag", irq_flags[0], 0);
      chk("R8 vsync flag while disabled", irq_flags[1], 1);
      repeat (5) @(negedge clk);
      chk("R10 flag held", irq_flags[1], 1);
      clr(3'b111);
      chk("R10 flag cleared", irq_flags, 0);

      enable = 1;
      repeat (6) @(negedge clk);
      chk("R3 idle before first load", sda_out, 1);

      hwrite(8'h5A);
      vpulse();
      chk("R5 first bit is msb", sda_out, 0);
      chk("R7 tx flag on load", irq_flags[0], 1);
      chk("R9 no underrun when fresh", irq_flags[2], 0);
      hwrite(8'hC3);
      clr(3'b011);
      for (int i = 6; i >= 0; i--) begin
         vpulse();
         chk("R5 data bit", sda_out, (8'h5A >> i) & 1);
      end
      chk("R7 no tx flag mid byte", irq_flags[0], 0);
      vpulse();
      chk("R6 null bit high", sda_out, 1);
      vpulse();
      chk("R6 next byte msb", sda_out, 1);
      chk("R7 tx flag second load", irq_flags[0], 1);
      chk("R9 no underrun", irq_flags[2], 0);
      vpulse();
      chk("R5 second byte bit6", sda_out, 1);

      // no write: underrun resend
      for (int i = 0; i < 7; i++) vpulse();
      chk("R6 null after second byte", sda_out, 1);
      clr(3'b111);
      vpulse();
      chk("R9 resend msb", sda_out, 1);
      chk("R9 underrun flag", irq_flags[2], 1);
      vpulse();
      chk("R9 resend bit6", sda_out, 1);
      vpulse();
      chk("R9 resend bit5", sda_out, 0);

      // disable mid byte, restart
      @(negedge clk) enable = 0;
      @(negedge clk);
      chk("R11 idle after disable", sda_out, 1);
      hwrite(8'h80);
      enable = 1;
      vpulse();
      chk("R11 restart loads msb", sda_out, 1);
      chk("R11 load flag", irq_flags[0], 1);
      vpulse();
      chk("R11 restart bit6", sda_out, 0);

      // latency and single strobe per high level
      clr(3'b111);
      @(negedge clk) vsync_in = 1;
      @(negedge clk);
      @(negedge clk);
      chk("R4 no strobe after two edges", irq_flags[1], 0);
      @(negedge clk);
      chk("R4 strobe at third edge", irq_flags[1], 1);
      repeat (5) @(negedge clk);
      clr(3'b010);
      repeat (15) @(negedge clk);
      chk("R4 one strobe per high level", irq_flags[1], 0);
      chk("R4 sda advanced once", sda_out, 0);
      vsync_in = 0;
      repeat (5) @(negedge clk);

      // set beats clear in the same clock
      @(negedge clk) irq_clr = 3'b010;
      vsync_in = 1;
      @(negedge clk); @(negedge clk); @(negedge clk);
      chk("R10 set wins over clear", irq_flags[1], 1);
      irq_clr = 0;
      vsync_in = 0;
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule